// File: doc/BRIEF.md
# Slot-Weighted Dispatch Group Tracker

This block follows a stream of decoded instructions as they are packed into dispatch groups of five slots. Every instruction arrives with a class code, a branch flag, a record-form flag, a load flag, its own tag and a short list of producer tags. From the class and the record-form flag the block gives the instruction a weight of 1, 2 or 4 slots. It then decides whether the instruction joins the open group, starts a new group, or finds the group already full. The block keeps the tags of the current group's members in a small table.

While an instruction is being presented, the block compares its producer tags with the group table in the same cycle. A load that depends on a store in the current group is a hazard. A branch that depends on a counter-setting instruction in the current group is also a hazard. For a hazard, the block reports how many filler no-ops the scheduler has to insert. It offers two padding modes: one group-terminating no-op, or enough ordinary no-ops to fill the group. When a filler no-op is emitted, the block closes the group or adds an empty slot to it.

Top module: `dgroup_tracker`

## Requirements
- R1: A synchronous reset sets the slot count and the branch count to 0, holds group_start low, and empties the group table. A load that names a tag from before the reset is then not a hazard.
- R2: The slot weight follows the class code. Codes 1 (divide) and 2 (update-form or algebraic load/store) take 2 slots. Codes 3 (indexed update), 4 (reserve/conditional) and 5 (move to condition register) take 4 slots. Every other code takes 1 slot.
- R3: When in_record is 1, an instruction that would take 1 slot takes 2 instead. Heavier weights do not change.
- R4: An instruction must lead its group if its weight is above 1 or its class is 6 (condition-register logical), 7 (move from condition register) or 8 (move to special register). If such an instruction arrives while the slot count is nonzero, the old group is dropped. The slot count then becomes the instruction's weight, and the branch count becomes its branch flag.
- R5: Suppose the slot count is 5 or more, or a branch arrives while the branch count is 1. The arriving instruction is then not counted, and both counts return to 0. Otherwise the weight is added to the slot count, and a branch adds 1 to the branch count.
- R6: load_store hazard: in_load is 1 and some valid producer with its store bit set carries a tag that is in the current group. hazard is raised in that same cycle, but only when in_stalled is 0.
- R7: counter hazard: in_branch is 1 and some valid producer with its counter-set bit set carries a tag that is in the current group. hazard is raised in that same cycle, but only when in_stalled is 0.
- R8: noop_count is 0 when there is no hazard or when the slot count is 6. Otherwise it is 1 when term_mode is 1, and 5 minus the slot count when term_mode is 0.
- R9: In a cycle with noop_emit=1 and in_valid=0, the group closes (both counts go to 0) if term_mode is 1 or the slot count is 6. In every other case the no-op adds one empty slot, and that slot matches no tag.
- R10: group_start is 1 for exactly the cycle after each edge that dropped a group. This covers the cases of R4, R5 and R9.
- R11: When in_valid is 1, noop_emit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| term_mode | input | 1 | 1: one terminating no-op pads a hazard |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_stalled | input | 1 | Stalls have accumulated; suppresses hazard |
| in_tag | input | TAG_W | Tag of the presented instruction |
| in_class | input | CLS_W | Class code |
| in_branch | input | 1 | Instruction is a branch |
| in_record | input | 1 | Instruction is record-form |
| in_load | input | 1 | Instruction is a load |
| pred_valid | input | NPRED | Producer entry is present |
| pred_store | input | NPRED | Producer is a store with a memory ordering dependence |
| pred_ctr | input | NPRED | Producer sets the counter register (data dependence) |
| pred_tag | input | NPRED*TAG_W | Producer tags, entry p in bits p*TAG_W upward |
| noop_emit | input | 1 | A filler no-op is emitted this cycle |
| slot_count | output | 3 | Slots used in the current group (0..6) |
| branch_count | output | 2 | Branches in the current group |
| group_start | output | 1 | Pulse: the previous edge dropped a group |
| hazard | output | 1 | Presented instruction has an in-group hazard |
| noop_count | output | 3 | Filler no-ops required |

## Verification
The bench uses the default build: 4-bit tags, two producer entries per instruction and a six-entry group table. With two producer entries, one instruction can name a store producer and a counter-setting producer at once, so the bench can check that each hazard kind needs its own kind bit. The tag values in the stimulus are drawn from 0..7, which gives random producer tags frequent hits on group members. Because no-ops pad the group up to six slots, the table fills completely, and the table-full boundary and the no-op-closes-at-six case are both reached.

// File: rtl/dgroup_tracker.sv
module dgroup_tracker #(
  parameter int TAG_W     = 4,
  parameter int CLS_W     = 4,
  parameter int NPRED     = 2,
  parameter int GDEPTH    = 6,
  parameter int MAX_SLOTS = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   term_mode,
  input  logic                   in_valid,
  input  logic                   in_stalled,
  input  logic [TAG_W-1:0]       in_tag,
  input  logic [CLS_W-1:0]       in_class,
  input  logic                   in_branch,
  input  logic                   in_record,
  input  logic                   in_load,
  input  logic [NPRED-1:0]       pred_valid,
  input  logic [NPRED-1:0]       pred_store,
  input  logic [NPRED-1:0]       pred_ctr,
  input  logic [NPRED*TAG_W-1:0] pred_tag,
  input  logic                   noop_emit,
  output logic [2:0]             slot_count,
  output logic [1:0]             branch_count,
  output logic                   group_start,
  output logic                   hazard,
  output logic [2:0]             noop_count
);
  localparam int PTR_W = $clog2(GDEPTH + 1);
  localparam logic [2:0] FULL  = 3'(MAX_SLOTS);
  localparam logic [2:0] LIMIT = 3'(MAX_SLOTS + 1);

  logic [TAG_W-1:0] tbl_tag [GDEPTH];
  logic [GDEPTH-1:0] tbl_v;
  logic [PTR_W-1:0]  ptr;
  logic [2:0]        slot_q;
  logic [1:0]        br_q;
  logic              gs_q;

  logic [2:0] base_w, wgt;
  logic       first_cls, must_first;

  always_comb begin
    case (in_class)
      CLS_W'(1), CLS_W'(2):            base_w = 3'd2;
      CLS_W'(3), CLS_W'(4), CLS_W'(5): base_w = 3'd4;
      default:                         base_w = 3'd1;
    endcase
  end

  assign wgt        = (base_w == 3'd1 && in_record) ? 3'd2 : base_w;
  assign first_cls  = (in_class == CLS_W'(6)) || (in_class == CLS_W'(7)) || (in_class == CLS_W'(8));
  assign must_first = (wgt > 3'd1) || first_cls;

  logic [NPRED-1:0] in_grp;
  genvar gp;
  generate
    for (gp = 0; gp < NPRED; gp++) begin : g_pred
      logic [GDEPTH-1:0] hit;
      for (genvar ge = 0; ge < GDEPTH; ge++) begin : g_ent
        assign hit[ge] = tbl_v[ge] && (tbl_tag[ge] == pred_tag[gp*TAG_W +: TAG_W]);
      end
      assign in_grp[gp] = pred_valid[gp] && (|hit);
    end
  endgenerate

  logic ls_hit, ctr_hit;
  assign ls_hit  = in_load   && |(in_grp & pred_store);
  assign ctr_hit = in_branch && |(in_grp & pred_ctr);
  assign hazard  = in_valid && !in_stalled && (ls_hit || ctr_hit);

  always_comb begin
    if (!hazard || slot_q >= LIMIT) noop_count = 3'd0;
    else if (term_mode)             noop_count = 3'd1;
    else                            noop_count = FULL - slot_q;
  end

  logic close_full, restart, noop_close, room;
  assign close_full = (slot_q >= FULL) || (in_branch && br_q == 2'd1);
  assign restart    = must_first && (slot_q != 3'd0);
  assign noop_close = term_mode || (slot_q == LIMIT);
  assign room       = ptr < PTR_W'(GDEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_v  <= '0;
      ptr    <= '0;
      slot_q <= '0;
      br_q   <= '0;
      gs_q   <= 1'b0;
    end else begin
      gs_q <= 1'b0;
      if (in_valid) begin
        if (close_full) begin
          tbl_v  <= '0;
          ptr    <= '0;
          slot_q <= '0;
          br_q   <= '0;
          gs_q   <= 1'b1;
        end else if (restart) begin
          tbl_v      <= GDEPTH'(1);
          tbl_tag[0] <= in_tag;
          ptr        <= PTR_W'(1);
          slot_q     <= wgt;
          br_q       <= {1'b0, in_branch};
          gs_q       <= 1'b1;
        end else begin
          if (room) begin
            tbl_v[ptr]   <= 1'b1;
            tbl_tag[ptr] <= in_tag;
            ptr          <= ptr + PTR_W'(1);
          end
          slot_q <= slot_q + wgt;
          br_q   <= br_q + {1'b0, in_branch};
        end
      end else if (noop_emit) begin
        if (noop_close) begin
          tbl_v  <= '0;
          ptr    <= '0;
          slot_q <= '0;
          br_q   <= '0;
          gs_q   <= 1'b1;
        end else begin
          if (room) begin
            tbl_v[ptr] <= 1'b0;
            ptr        <= ptr + PTR_W'(1);
          end
          slot_q <= slot_q + 3'd1;
        end
      end
    end
  end

  assign slot_count   = slot_q;
  assign branch_count = br_q;
  assign group_start  = gs_q;
endmodule

module dgroup_tracker_chk (
  input logic       clk,
  input logic       rst,
  input logic       term_mode,
  input logic       in_valid,
  input logic       in_stalled,
  input logic       noop_emit,
  input logic [2:0] slot_count,
  input logic [1:0] branch_count,
  input logic       group_start,
  input logic       hazard,
  input logic [2:0] noop_count
);
  assert_slot_bound_R9: assert property (@(posedge clk) disable iff (rst)
    slot_count <= 3'd6);

  assert_branch_bound_R5: assert property (@(posedge clk) disable iff (rst)
    branch_count <= 2'd1);

  assert_full_close_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot_count >= 3'd5) |=> (slot_count == 3'd0 && group_start));

  assert_noop_needs_hazard_R8: assert property (@(posedge clk) disable iff (rst)
    (noop_count != 3'd0) |-> hazard);

  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    in_stalled |-> !hazard);

  assert_term_noop_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && noop_emit && term_mode) |=> (slot_count == 3'd0 && group_start));

  assert_start_low_R10: assert property (@(posedge clk) disable iff (rst)
    group_start |-> slot_count <= 3'd4);
endmodule

bind dgroup_tracker dgroup_tracker_chk u_chk (
  .clk(clk), .rst(rst), .term_mode(term_mode), .in_valid(in_valid),
  .in_stalled(in_stalled), .noop_emit(noop_emit), .slot_count(slot_count),
  .branch_count(branch_count), .group_start(group_start), .hazard(hazard),
  .noop_count(noop_count)
);

// File: tb/dgroup_tracker_bench.sv
module dgroup_tracker_bench;
  logic clk = 0, rst = 1, term_mode = 0, in_valid = 0, in_stalled = 0;
  logic [3:0] in_tag = 0, in_class = 0;
  logic in_branch = 0, in_record = 0, in_load = 0, noop_emit = 0;
  logic [1:0] pred_valid = 0, pred_store = 0, pred_ctr = 0;
  logic [7:0] pred_tag = 0;
  logic [2:0] slot_count, noop_count;
  logic [1:0] branch_count;
  logic group_start, hazard;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_slots = 0, m_br = 0, m_gs = 0;
  int q[$];

  always #5 clk = ~clk;

  dgroup_tracker u_dgroup_tracker (
    .clk(clk), .rst(rst), .term_mode(term_mode), .in_valid(in_valid),
    .in_stalled(in_stalled), .in_tag(in_tag), .in_class(in_class),
    .in_branch(in_branch), .in_record(in_record), .in_load(in_load),
    .pred_valid(pred_valid), .pred_store(pred_store), .pred_ctr(pred_ctr),
    .pred_tag(pred_tag), .noop_emit(noop_emit), .slot_count(slot_count),
    .branch_count(branch_count), .group_start(group_start), .hazard(hazard),
    .noop_count(noop_count)
  );

  function automatic int weight(int c, bit rec);
    int w;
    if (c == 1 || c == 2) w = 2;
    else if (c >= 3 && c <= 5) w = 4;
    else w = 1;
    if (w == 1 && rec) w = 2;
    return w;
  endfunction

  function automatic bit member(int t);
    foreach (q[i]) if (q[i] == t) return 1;
    return 0;
  endfunction

  function automatic int exp_hazard();
    bit h = 0;
    if (!in_valid || in_stalled) return 0;
    for (int p = 0; p < 2; p++) begin
      if (pred_valid[p] && member(int'(pred_tag[p*4 +: 4]))) begin
        if (in_load && pred_store[p]) h = 1;
        if (in_branch && pred_ctr[p]) h = 1;
      end
    end
    return h;
  endfunction

  function automatic int exp_noops();
    if (exp_hazard() == 0 || m_slots >= 6) return 0;
    return term_mode ? 1 : 5 - m_slots;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "slot_count", int'(slot_count), m_slots);
    chk(req, "branch_count", int'(branch_count), m_br);
    chk(req, "group_start", int'(group_start), m_gs);
    chk(req, "hazard", int'(hazard), exp_hazard());
    chk(req, "noop_count", int'(noop_count), exp_noops());
  endtask

  task automatic model_clear();
    q.delete(); m_slots = 0; m_br = 0;
  endtask

  task automatic model_edge();
    int w;
    bit first;
    m_gs = 0;
    if (in_valid) begin
      w = weight(int'(in_class), in_record);
      first = (w > 1) || in_class == 6 || in_class == 7 || in_class == 8;
      if (m_slots >= 5 || (in_branch && m_br == 1)) begin
        model_clear(); m_gs = 1;
      end else begin
        if (first && m_slots != 0) begin model_clear(); m_gs = 1; end
        q.push_back(int'(in_tag));
        m_slots += w;
        m_br += int'(in_branch);
      end
    end else if (noop_emit) begin
      if (term_mode || m_slots == 6) begin model_clear(); m_gs = 1; end
      else begin q.push_back(-1); m_slots++; end
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; noop_emit = 0; in_stalled = 0; in_branch = 0; in_record = 0;
    in_load = 0; pred_valid = 0; pred_store = 0; pred_ctr = 0; in_class = 0;
  endtask

  task automatic step(string req);
    #1 compare(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic ins(string req, int cls, int tag, bit br = 0, bit rec = 0);
    idle_inputs();
    in_valid = 1; in_class = 4'(cls); in_tag = 4'(tag); in_branch = br; in_record = rec;
    step(req);
  endtask

  task automatic dep(string req, bit ld, bit br, int t0, bit st0, bit ct0, bit stall = 0);
    idle_inputs();
    in_valid = 1; in_class = 0; in_tag = 4'd15; in_load = ld; in_branch = br;
    in_stalled = stall; pred_valid = 2'b01; pred_tag = {4'd0, 4'(t0)};
    pred_store = {1'b0, st0}; pred_ctr = {1'b0, ct0};
    #1 compare(req);
    idle_inputs();
    #1;
  endtask

  task automatic noop(string req);
    idle_inputs(); noop_emit = 1; step(req);
  endtask

  task automatic do_reset(string req);
    idle_inputs(); rst = 1;
    @(posedge clk); model_clear(); m_gs = 0;
    @(negedge clk); rst = 0;
    #1 compare(req);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R1");
    // R2 weights and R4 leading rule
    ins("R2", 0, 1);
    ins("R4", 1, 2);
    ins("R2", 0, 3);
    ins("R4", 3, 4);
    ins("R2", 0, 5);
    ins("R3", 0, 6, 0, 1);
    ins("R3", 4, 7, 0, 1);
    ins("R4", 6, 1);
    ins("R4", 0, 2);
    ins("R4", 8, 3, 1);
    idle_inputs(); step("R10");
    // R5 full close and second branch
    do_reset("R1");
    for (int i = 0; i < 5; i++) ins("R5", 0, i);
    ins("R5", 0, 9);
    idle_inputs(); step("R10");
    ins("R5", 0, 1, 1);
    ins("R5", 0, 2, 1);
    ins("R5", 0, 3, 1);
    // R6 load after store, R7 counter then branch, R8 counts
    do_reset("R1");
    ins("R6", 0, 3);
    ins("R6", 0, 4);
    term_mode = 0;
    dep("R6", 1, 0, 3, 1, 0);
    dep("R8", 1, 0, 4, 1, 0);
    dep("R6", 1, 0, 3, 1, 0, 1);
    dep("R6", 1, 0, 3, 0, 1);
    dep("R6", 0, 0, 3, 1, 0);
    dep("R6", 1, 0, 9, 1, 0);
    term_mode = 1;
    dep("R8", 1, 0, 3, 1, 0);
    term_mode = 0;
    do_reset("R1");
    ins("R7", 8, 5);
    dep("R7", 0, 1, 5, 0, 1);
    dep("R7", 0, 1, 5, 1, 0);
    dep("R7", 0, 1, 5, 0, 1, 1);
    // R9 no-op emission
    do_reset("R1");
    for (int i = 0; i < 5; i++) ins("R9", 0, i);
    noop("R9");
    dep("R8", 1, 0, 2, 1, 0);
    noop("R9");
    idle_inputs(); step("R10");
    ins("R9", 0, 6);
    noop("R9");
    dep("R9", 1, 0, 6, 1, 0);
    term_mode = 1;
    noop("R9");
    idle_inputs(); step("R10");
    term_mode = 0;
    // R11 no-op ignored beside an instruction
    ins("R11", 0, 1);
    idle_inputs(); in_valid = 1; in_tag = 2; noop_emit = 1; step("R11");
    idle_inputs(); step("R11");
    // R1 reset empties the table
    ins("R1", 0, 7);
    do_reset("R1");
    dep("R1", 1, 0, 7, 1, 0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      if ($urandom_range(0, 99) < 3) term_mode = ~term_mode;
      in_valid   = ($urandom_range(0, 99) < 75);
      noop_emit  = ($urandom_range(0, 99) < 25);
      in_stalled = ($urandom_range(0, 99) < 10);
      in_class   = 4'($urandom_range(0, 10));
      in_tag     = 4'($urandom_range(0, 7));
      in_branch  = ($urandom_range(0, 99) < 20);
      in_record  = ($urandom_range(0, 99) < 15);
      in_load    = ($urandom_range(0, 99) < 30);
      pred_valid = 2'($urandom_range(0, 3));
      pred_store = 2'($urandom_range(0, 3));
      pred_ctr   = 2'($urandom_range(0, 3));
      pred_tag   = {4'($urandom_range(0, 7)), 4'($urandom_range(0, 7))};
      step("random");
      if ($urandom_range(0, 999) < 5) do_reset("R1");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule